// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries 8-bit PCM samples between a codec core and a time-division serial bus. The bus has one bit clock and two frame-sync inputs, one for the transmit direction and one for the receive direction. Each direction has its own frame-bit counter. The counter restarts on a frame-sync rising edge and picks out the 8-bit slot that belongs to this device. Transmit bits are launched on bit-clock rising edges. Receive bits are captured on bit-clock falling edges.

The block runs on a fast system clock. The bit clock is sampled and turned into rising and falling event strobes. Configuration comes from static register fields:
- a framing-mode bit;
- a 7-bit slot number for each direction;
- a port select for each direction.

There are two transmit ports and two receive ports, and only the selected one of each is used. Each transmit port has an active-low strobe that enables an external backplane line driver. The strobe covers the first seven and a half bits of the slot. Each transmit port also has an output enable, which models the high-impedance state of its serial output.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, both output enables are 0, both driver strobes are 1, both serial data outputs are 0, and `rx_valid_o` is 0.
- R2: With `delayed_i`=0 (non-delayed framing), a bit-clock rising edge at which the frame sync is first seen high begins bit 0 of slot 0. The slot registers are ignored, and slot 0 is always used.
- R3: With `delayed_i`=1 (delayed framing), the frame sync is sampled on falling edges. A low-to-high change seen there makes the next rising edge begin bit 0 of slot 0. Slot n starts 8·n bit clocks after slot 0, where n is the 7-bit slot register value.
- R4: In the transmit slot, `tx_data_i` is latched when the slot begins and sent MSB first, one bit per rising edge. Changes to `tx_data_i` after the slot has begun do not affect the byte sent. Outputs change one system clock after the rising edge is sampled.
- R5: In the receive slot, the selected receive input is shifted in MSB first on each falling edge. One system clock after the eighth falling edge, `rx_valid_o` pulses for exactly one clock and `rx_data_o` holds the byte.
- R6: The selected driver strobe goes low with the first bit of the transmit slot. It returns high at the falling edge inside the eighth bit, while the output enable is still high.
- R7: Transmit port select value k routes data, output enable and strobe to port k only. The other port keeps its output enable at 0, its data at 0 and its strobe at 1. Receive port select value k takes data from `dr_i[k]`, and the other receive input is ignored.
- R8: The transmit and receive frames are timed independently, and their frame syncs may be offset by any number of bit clocks.
- R9: A frame sync held high for several bit clocks starts only one frame. Only its rising edge counts.
- R10: Outside the assigned transmit slot, and after 2^(7+3) bits from frame start, the output enable is 0 and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| fs_tx_i | input | 1 | Transmit frame sync |
| fs_rx_i | input | 1 | Receive frame sync |
| delayed_i | input | 1 | 1 = delayed framing with slot assignment, 0 = non-delayed |
| tx_slot_i | input | 7 | Transmit slot number from frame start |
| rx_slot_i | input | 7 | Receive slot number from frame start |
| tx_port_i | input | 1 | Transmit port select |
| rx_port_i | input | 1 | Receive port select |
| tx_data_i | input | 8 | Byte to transmit |
| dr_i | input | 2 | Serial receive inputs |
| dx_o | output | 2 | Serial transmit outputs |
| dx_oe_o | output | 2 | Output enables of the transmit outputs |
| ts_no | output | 2 | Active-low backplane driver strobes |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse when a byte completes |

## Verification
The assertions assume that `bclk_i` stays high and low for at least two system clocks each. They also assume that the port select and mode fields only change while reset is held, and that frame syncs and receive data change together with a bit-clock rising edge. The bench builds every bit-clock phase from four system clocks. It changes frame syncs, receive bits and transmit data only at the moment it raises the bit clock. It applies a reset before each new configuration, so the checked timing relations are never disturbed by a live register change.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] pcm_byte_t;
endpackage

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int unsigned SLOT_W = 7,
  localparam int unsigned CNT_W = SLOT_W + pcm_slot_pkg::BIT_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             delayed_i,
  input  logic             fs_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             run_o,
  output logic [CNT_W-1:0] pos_nxt_o,
  output logic             run_nxt_o
);
  logic             fs_q, pend_q, run_q;
  logic [CNT_W-1:0] pos_q;
  logic             sample_ev, fs_edge, start;

  assign sample_ev = delayed_i ? fall_i : rise_i;
  assign fs_edge   = sample_ev & fs_i & ~fs_q;
  assign start     = rise_i & (delayed_i ? pend_q : fs_edge);

  always_comb begin
    pos_nxt_o = pos_q;
    run_nxt_o = run_q;
    if (start) begin
      pos_nxt_o = '0;
      run_nxt_o = 1'b1;
    end else if (rise_i && run_q) begin
      if (pos_q == '1) run_nxt_o = 1'b0;  // stop at counter end
      else             pos_nxt_o = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
      pos_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      if (sample_ev) fs_q <= fs_i;
      if (rise_i)                      pend_q <= 1'b0;
      else if (delayed_i && fs_edge)   pend_q <= 1'b1;
      pos_q <= pos_nxt_o;
      run_q <= run_nxt_o;
    end
  end

  assign pos_o = pos_q;
  assign run_o = run_q;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_slot_pkg::*;
#(
  parameter int unsigned SLOT_W = 7,
  localparam int unsigned CNT_W = SLOT_W + BIT_IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 delayed_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  pcm_byte_t            data_i,
  input  logic [BIT_IDX_W-1:0] bit_cur_i,
  input  logic [CNT_W-1:0]     pos_nxt_i,
  input  logic                 run_nxt_i,
  output logic                 dx_o,
  output logic                 oe_o,
  output logic                 ts_no
);
  pcm_byte_t         sh_q;
  logic [SLOT_W-1:0] eff_slot;
  logic              in_nxt;

  assign eff_slot = delayed_i ? slot_i : '0;
  assign in_nxt   = run_nxt_i && (pos_nxt_i[CNT_W-1:BIT_IDX_W] == eff_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      dx_o  <= 1'b0;
      oe_o  <= 1'b0;
      ts_no <= 1'b1;
    end else if (rise_i) begin
      oe_o  <= in_nxt;
      ts_no <= ~in_nxt;
      if (!in_nxt) begin
        dx_o <= 1'b0;
      end else if (pos_nxt_i[BIT_IDX_W-1:0] == '0) begin
        dx_o <= data_i[BYTE_W-1];
        sh_q <= {data_i[BYTE_W-2:0], 1'b0};
      end else begin
        dx_o <= sh_q[BYTE_W-1];
        sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      end
    end else if (fall_i && oe_o && (bit_cur_i == '1)) begin
      ts_no <= 1'b1;  // release half a bit before slot end
    end
  end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_slot_pkg::*;
#(
  parameter int unsigned SLOT_W = 7,
  localparam int unsigned CNT_W = SLOT_W + BIT_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              delayed_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              run_i,
  input  logic              dr_i,
  output pcm_byte_t         data_o,
  output logic              valid_o
);
  pcm_byte_t         sh_q;
  logic [SLOT_W-1:0] eff_slot;
  logic              take;

  assign eff_slot = delayed_i ? slot_i : '0;
  assign take     = fall_i && run_i && (pos_i[CNT_W-1:BIT_IDX_W] == eff_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (take) begin
        sh_q <= {sh_q[BYTE_W-2:0], dr_i};
        if (pos_i[BIT_IDX_W-1:0] == '1) begin
          data_o  <= {sh_q[BYTE_W-2:0], dr_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int unsigned SLOT_W    = 7,
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bclk_i,
  input  logic                         fs_tx_i,
  input  logic                         fs_rx_i,
  input  logic                         delayed_i,
  input  logic [SLOT_W-1:0]            tx_slot_i,
  input  logic [SLOT_W-1:0]            rx_slot_i,
  input  logic [$clog2(NUM_PORTS)-1:0] tx_port_i,
  input  logic [$clog2(NUM_PORTS)-1:0] rx_port_i,
  input  logic [BYTE_W-1:0]            tx_data_i,
  input  logic [NUM_PORTS-1:0]         dr_i,
  output logic [NUM_PORTS-1:0]         dx_o,
  output logic [NUM_PORTS-1:0]         dx_oe_o,
  output logic [NUM_PORTS-1:0]         ts_no,
  output logic [BYTE_W-1:0]            rx_data_o,
  output logic                         rx_valid_o
);
  localparam int unsigned CNT_W = SLOT_W + BIT_IDX_W;

  logic bclk_q, rise, fall;
  logic [CNT_W-1:0] tx_pos, tx_pos_nxt, rx_pos, rx_pos_nxt;
  logic tx_run, tx_run_nxt, rx_run, rx_run_nxt;
  logic dx_q, oe_q, ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end
  assign rise = bclk_i & ~bclk_q;
  assign fall = ~bclk_i & bclk_q;

  pcm_frame_ctr #(.SLOT_W(SLOT_W)) u_tx_ctr (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .delayed_i,
    .fs_i(fs_tx_i), .pos_o(tx_pos), .run_o(tx_run),
    .pos_nxt_o(tx_pos_nxt), .run_nxt_o(tx_run_nxt)
  );

  pcm_frame_ctr #(.SLOT_W(SLOT_W)) u_rx_ctr (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .delayed_i,
    .fs_i(fs_rx_i), .pos_o(rx_pos), .run_o(rx_run),
    .pos_nxt_o(rx_pos_nxt), .run_nxt_o(rx_run_nxt)
  );

  pcm_tx_lane #(.SLOT_W(SLOT_W)) u_tx (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .delayed_i,
    .slot_i(tx_slot_i), .data_i(tx_data_i),
    .bit_cur_i(tx_pos[BIT_IDX_W-1:0]), .pos_nxt_i(tx_pos_nxt),
    .run_nxt_i(tx_run_nxt), .dx_o(dx_q), .oe_o(oe_q), .ts_no(ts_q)
  );

  pcm_rx_lane #(.SLOT_W(SLOT_W)) u_rx (
    .clk_i, .rst_ni, .fall_i(fall), .delayed_i,
    .slot_i(rx_slot_i), .pos_i(rx_pos), .run_i(rx_run),
    .dr_i(dr_i[rx_port_i]), .data_o(rx_data_o), .valid_o(rx_valid_o)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    logic sel;
    assign sel        = (tx_port_i == k);
    assign dx_o[k]    = sel & dx_q;
    assign dx_oe_o[k] = sel & oe_q;
    assign ts_no[k]   = ~sel | ts_q;
  end

  // tx_pos upper bits and next-state of rx counter are not needed downstream
  logic unused_ok;
  assign unused_ok = ^{tx_pos[CNT_W-1:BIT_IDX_W], tx_run, rx_pos_nxt, rx_run_nxt};
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         bclk_i,
  input logic [$clog2(NUM_PORTS)-1:0] tx_port_i,
  input logic [NUM_PORTS-1:0]         dx_o,
  input logic [NUM_PORTS-1:0]         dx_oe_o,
  input logic [NUM_PORTS-1:0]         ts_no,
  input logic                         rx_valid_o
);
  a_r7_oe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dx_oe_o));

  a_r6_strobe_inside_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~ts_no & ~dx_oe_o) == '0));

  a_r4_oe_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dx_oe_o != $past(dx_oe_o)) |-> ($past(bclk_i) && !$past(bclk_i, 2)));

  a_r6_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ts_no & ~$past(ts_no) & dx_oe_o)) |-> (!$past(bclk_i) && $past(bclk_i, 2)));

  a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r5_valid_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (!$past(bclk_i) && $past(bclk_i, 2)));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
    a_r7_unselected_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_port_i != k) |-> (!dx_oe_o[k] && !dx_o[k] && ts_no[k]));
  end
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_i), .tx_port_i(tx_port_i),
  .dx_o(dx_o), .dx_oe_o(dx_oe_o), .ts_no(ts_no), .rx_valid_o(rx_valid_o)
);

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bclk_i = 1'b0, fs_tx_i = 1'b0, fs_rx_i = 1'b0, delayed_i = 1'b0;
  logic [6:0] tx_slot_i = '0, rx_slot_i = '0;
  logic       tx_port_i = 1'b0, rx_port_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic [1:0] dr_i = '0;
  logic [1:0] dx_o, dx_oe_o, ts_no;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pcm_slot_port dut (.*);

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; bclk_i = 1'b0; fs_tx_i = 1'b0; fs_rx_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  function automatic bit in_slot(int p, int eslot);
    return (p >= 0) && (p < 1024) && (p / 8 == eslot);
  endfunction

  task automatic run_scn(bit dly, int tslot, int rslot, bit tp, bit rp,
                         int ftx, int frx, int fslen, logic [7:0] tbyte);
    int ets, ers, d, last;
    logic [7:0] acc;
    string mtag;
    delayed_i = dly; tx_slot_i = 7'(tslot); rx_slot_i = 7'(rslot);
    tx_port_i = tp; rx_port_i = rp; tx_data_i = tbyte;
    do_reset();
    ets  = dly ? tslot : 0;
    ers  = dly ? rslot : 0;
    d    = dly ? 1 : 0;
    mtag = (fslen > 1) ? "R9" : (dly ? "R3" : "R2");
    last = ((ftx > frx) ? ftx : frx) + d + 8 * (((ets > ers) ? ets : ers) + 1) + 3;
    acc  = '0;
    for (int c = 0; c <= last; c++) begin
      int  pt, pr;
      bit  it, ir;
      pt = c - ftx - d;
      pr = c - frx - d;
      it = in_slot(pt, ets);
      ir = in_slot(pr, ers);
      // rising half
      bclk_i  = 1'b1;
      fs_tx_i = (c >= ftx) && (c < ftx + fslen);
      fs_rx_i = (c >= frx) && (c < frx + fslen);
      dr_i    = 2'($urandom);
      if (it && (pt % 8 == 1)) tx_data_i = 8'($urandom);  // R4: must not disturb latched byte
      @(negedge clk_i);
      for (int k = 0; k < 2; k++) begin
        bit    eo;
        string t;
        eo = it && (tp == k);
        t  = (tp != k) ? "R7" : (!it ? "R10" : mtag);
        check(t, $sformatf("oe[%0d] bit %0d", k, c), int'(dx_oe_o[k]), int'(eo));
        check(it && tp == k ? "R4" : t, $sformatf("dx[%0d] bit %0d", k, c),
              int'(dx_o[k]), eo ? int'(tbyte[7 - pt % 8]) : 0);
        check(tp != k ? "R7" : "R6", $sformatf("ts rise[%0d] bit %0d", k, c),
              int'(ts_no[k]), int'(!eo));
      end
      check("R5", "valid after rise", int'(rx_valid_o), 0);
      repeat (3) @(negedge clk_i);
      // falling half
      bclk_i = 1'b0;
      @(negedge clk_i);
      for (int k = 0; k < 2; k++)
        check("R6", $sformatf("ts fall[%0d] bit %0d", k, c), int'(ts_no[k]),
              int'(!(it && tp == k && (pt % 8 != 7))));
      if (ir) acc = {acc[6:0], dr_i[rp]};
      check(ftx != frx ? "R8" : "R5", $sformatf("rx valid bit %0d", c),
            int'(rx_valid_o), int'(ir && (pr % 8 == 7)));
      if (ir && (pr % 8 == 7))
        check(rp ? "R7" : "R5", "rx data", int'(rx_data_o), int'(acc));
      repeat (3) @(negedge clk_i);
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    do_reset();
    check("R1", "oe reset", int'(dx_oe_o), 0);
    check("R1", "ts reset", int'(ts_no), 3);
    check("R1", "dx reset", int'(dx_o), 0);
    check("R1", "valid reset", int'(rx_valid_o), 0);
    // directed corners
    run_scn(1'b0, 5, 3, 1'b0, 1'b0, 2, 2, 1, 8'hA5);   // R2 slot regs ignored
    run_scn(1'b1, 2, 1, 1'b1, 1'b1, 1, 4, 1, 8'h3C);   // R3, R7, R8
    run_scn(1'b1, 0, 0, 1'b0, 1'b1, 0, 0, 1, 8'h81);
    run_scn(1'b1, 127, 0, 1'b1, 1'b0, 0, 0, 1, 8'h5A); // last slot of counter
    run_scn(1'b0, 0, 0, 1'b1, 1'b0, 3, 0, 9, 8'hF0);   // R9 long sync
    for (int i = 0; i < 12; i++)
      run_scn(1'($urandom), int'($urandom % 12), int'($urandom % 12),
              1'($urandom), 1'($urandom), int'($urandom % 10),
              int'($urandom % 10), 1 + int'($urandom % 12), 8'($urandom));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule